// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an instruction's address field into the address of its operand, following one of nine addressing modes chosen by a four-bit mode code. The caller holds the address field, the location of that field, the already advanced program counter, a register index and a mode on the inputs, and pulses `start`. The block reads one register-file port in the same cycle. It returns the effective address together with a one-cycle `ea_valid` strobe.

Most modes finish one cycle after `start`. These modes use only an adder or a selector over values that are present when `start` is pulsed. The memory-indirect mode is different. It places the address field on a memory read port, waits for the read data to return and then reports that word as the address. During the wait the block shows `busy` and ignores any further `start`. Register and implicit modes have no memory operand, so they raise `ea_is_reg` and report an address of zero.

Top module: `opnd_ea_gen`

## Requirements
- R1: After reset, `ea_valid`, `busy` and `mem_req` are all 0.
- R2: Direct mode (code 2) gives `ea` = `field_val`, with `ea_valid` high in the cycle after `start` and `ea_is_reg` = 0.
- R3: Immediate mode (code 1) gives `ea` = `field_loc`, which is the location of the operand word itself. For a field at 351, `ea` = 351.
- R4: PC-relative mode (code 6) gives `ea` = `pc_next` + `field_val`, wrapping modulo 2^AW. For example, 352 + 400 = 752, and 0xFFF0 + 0x0020 = 0x0010.
- R5: Base-register mode (code 7) and indexed mode (code 8) give `ea` = `rf_data` + `field_val`, with `rf_sel` driven by `reg_idx`. Base 3000 with offset 20 gives 3020. Field 400 with index 200 gives 600.
- R6: Register-indirect mode (code 5) gives `ea` = `rf_data`, the content of the selected register. With that register at 200, `ea` = 200.
- R7: Implicit mode (code 0), register mode (code 4) and the unused codes 9 to 15 give `ea_is_reg` = 1 and `ea` = 0, one cycle after `start`.
- R8: Indirect mode (code 3) raises `mem_req` in the cycle after `start`, with `mem_addr` = `field_val`. Both stay unchanged until `mem_rvalid`. In the cycle after `mem_rvalid`, `ea_valid` is high, `ea` = `mem_rdata` and `ea_is_reg` = 0.
- R9: While `busy` is high, `start` is ignored. No extra result is produced, and the pending indirect result is not altered.
- R10: `ea_valid` never rises while `busy` is high. `ea` and `ea_is_reg` hold their last values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation, accepted when not busy |
| mode | input | 4 | Addressing mode code |
| field_val | input | AW | Address field of the instruction |
| field_loc | input | AW | Location of the address field word |
| pc_next | input | AW | Program counter already advanced past the instruction |
| reg_idx | input | RW | Register selected by the instruction |
| rf_sel | output | RW | Register-file read select |
| rf_data | input | AW | Register-file read data, combinational |
| mem_req | output | 1 | Indirect read request, held until data returns |
| mem_addr | output | AW | Indirect read address |
| mem_rdata | input | AW | Indirect read data |
| mem_rvalid | input | 1 | Indirect read data valid |
| busy | output | 1 | Indirect dereference in progress |
| ea_valid | output | 1 | One-cycle result strobe |
| ea | output | AW | Effective address |
| ea_is_reg | output | 1 | Operand lives in a register, no memory address |

## Verification
The bench builds the block with its defaults: a 16-bit address width, eight registers and the indirect path enabled. The 16-bit width allows the decimal examples to be used directly, and it allows a relative sum that wraps past 0xFFFF. The bench's memory model answers after three cycles, which opens a window in which a second `start` can be shown to be ignored. Keeping the indirect path enabled makes the exact latency from `start` to strobe measurable against the read delay.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;
   typedef enum logic [3:0] {
      AM_IMPLICIT = 4'd0,
      AM_IMMED    = 4'd1,
      AM_DIRECT   = 4'd2,
      AM_INDIRECT = 4'd3,
      AM_REG      = 4'd4,
      AM_REG_IND  = 4'd5,
      AM_PC_REL   = 4'd6,
      AM_BASE     = 4'd7,
      AM_INDEXED  = 4'd8
   } amode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } ea_state_e;
endpackage

// File: rtl/opnd_ea_calc.sv
module opnd_ea_calc
   import opnd_ea_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [3:0]    mode,
   input  logic [AW-1:0] field_val,
   input  logic [AW-1:0] field_loc,
   input  logic [AW-1:0] pc_next,
   input  logic [AW-1:0] rf_data,
   output logic [AW-1:0] ea_c,
   output logic          is_reg_c
);
   logic [AW-1:0] disp_sum;
   logic [AW-1:0] rel_sum;

   // Shared displacement adder for base and indexed modes; wraps modulo 2^AW.
   assign disp_sum = rf_data + field_val;
   assign rel_sum  = pc_next + field_val;

   always_comb begin
      ea_c     = '0;
      is_reg_c = 1'b0;
      case (mode)
         AM_IMMED:              ea_c = field_loc;
         AM_DIRECT,
         AM_INDIRECT:           ea_c = field_val;   // indirect falls back to direct when disabled
         AM_REG_IND:            ea_c = rf_data;
         AM_PC_REL:             ea_c = rel_sum;
         AM_BASE, AM_INDEXED:   ea_c = disp_sum;
         default:               is_reg_c = 1'b1;    // implicit, register, unused codes
      endcase
   end
endmodule

// File: rtl/opnd_ea_seq.sv
module opnd_ea_seq
   import opnd_ea_pkg::*;
#(
   parameter int AW          = 16,
   parameter bit INDIRECT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    mode,
   input  logic [AW-1:0] field_val,
   input  logic [AW-1:0] ea_c,
   input  logic          is_reg_c,
   input  logic [AW-1:0] mem_rdata,
   input  logic          mem_rvalid,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic          busy,
   output logic          ea_valid,
   output logic [AW-1:0] ea,
   output logic          ea_is_reg
);
   ea_state_e state;
   logic      accept;
   logic      go_ind;

   assign accept = start && (state == ST_IDLE);
   assign busy   = (state == ST_WAIT);

   generate
      if (INDIRECT_EN) begin : g_ind
         assign go_ind = accept && (mode == AM_INDIRECT);
      end else begin : g_no_ind
         assign go_ind = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mem_req   <= 1'b0;
         mem_addr  <= '0;
         ea_valid  <= 1'b0;
         ea        <= '0;
         ea_is_reg <= 1'b0;
      end else begin
         ea_valid <= 1'b0;
         if (state == ST_WAIT) begin
            if (mem_rvalid) begin
               state     <= ST_IDLE;
               mem_req   <= 1'b0;
               ea        <= mem_rdata;
               ea_is_reg <= 1'b0;
               ea_valid  <= 1'b1;
            end
         end else if (go_ind) begin
            state    <= ST_WAIT;
            mem_req  <= 1'b1;
            mem_addr <= field_val;
         end else if (accept) begin
            ea        <= ea_c;
            ea_is_reg <= is_reg_c;
            ea_valid  <= 1'b1;
         end
      end
   end

   // R2: a non-indirect start yields a strobe one cycle later
   a_r2_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (mode != AM_INDIRECT)) |=> ea_valid);

   // R8: request address held steady until the read returns
   a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   // R8: indirect start opens a read and produces no immediate strobe
   a_r8_ind_enters: assert property (@(posedge clk) disable iff (!rst_n)
      (INDIRECT_EN && start && !busy && (mode == AM_INDIRECT)) |=> (mem_req && !ea_valid));

   // R10: no strobe while the dereference is still pending
   a_r10_no_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ea_valid |-> !busy);

   // R7: register-resident results carry a zero address
   a_r7_reg_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ea_valid && ea_is_reg) |-> (ea == '0));
endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
   import opnd_ea_pkg::*;
#(
   parameter int AW          = 16,
   parameter int NREGS       = 8,
   parameter bit INDIRECT_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [3:0]               mode,
   input  logic [AW-1:0]            field_val,
   input  logic [AW-1:0]            field_loc,
   input  logic [AW-1:0]            pc_next,
   input  logic [$clog2(NREGS)-1:0] reg_idx,
   output logic [$clog2(NREGS)-1:0] rf_sel,
   input  logic [AW-1:0]            rf_data,
   output logic                     mem_req,
   output logic [AW-1:0]            mem_addr,
   input  logic [AW-1:0]            mem_rdata,
   input  logic                     mem_rvalid,
   output logic                     busy,
   output logic                     ea_valid,
   output logic [AW-1:0]            ea,
   output logic                     ea_is_reg
);
   localparam int RW = $clog2(NREGS);

   generate
      if (AW < 4) begin : g_bad_aw
         $error("opnd_ea_gen: AW must be at least 4");
      end
      if (NREGS < 2) begin : g_bad_nregs
         $error("opnd_ea_gen: NREGS must be at least 2");
      end
   endgenerate

   logic [AW-1:0] ea_c;
   logic          is_reg_c;

   assign rf_sel = reg_idx[RW-1:0];

   opnd_ea_calc #(.AW(AW)) u_calc (
      .mode      (mode),
      .field_val (field_val),
      .field_loc (field_loc),
      .pc_next   (pc_next),
      .rf_data   (rf_data),
      .ea_c      (ea_c),
      .is_reg_c  (is_reg_c)
   );

   opnd_ea_seq #(.AW(AW), .INDIRECT_EN(INDIRECT_EN)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mode       (mode),
      .field_val  (field_val),
      .ea_c       (ea_c),
      .is_reg_c   (is_reg_c),
      .mem_rdata  (mem_rdata),
      .mem_rvalid (mem_rvalid),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .busy       (busy),
      .ea_valid   (ea_valid),
      .ea         (ea),
      .ea_is_reg  (ea_is_reg)
   );
endmodule

// File: tb/opnd_ea_gen_test.sv
module opnd_ea_gen_test;
   localparam int AW  = 16;
   localparam int LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3:0]    mode = 4'd0;
   logic [AW-1:0] field_val = '0;
   logic [AW-1:0] field_loc = '0;
   logic [AW-1:0] pc_next = '0;
   logic [2:0]    reg_idx = 3'd0;
   logic [2:0]    rf_sel;
   logic [AW-1:0] rf_data;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic [AW-1:0] mem_rdata = '0;
   logic          mem_rvalid = 1'b0;
   logic          busy, ea_valid, ea_is_reg;
   logic [AW-1:0] ea;

   logic [AW-1:0] regs [8];
   int            mcnt = 0;
   int            n_checks = 0;
   int            n_fail = 0;

   always #5 clk = ~clk;

   opnd_ea_gen uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .field_val(field_val), .field_loc(field_loc), .pc_next(pc_next),
      .reg_idx(reg_idx), .rf_sel(rf_sel), .rf_data(rf_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_rvalid(mem_rvalid), .busy(busy), .ea_valid(ea_valid),
      .ea(ea), .ea_is_reg(ea_is_reg)
   );

   always_comb rf_data = regs[rf_sel];

   function automatic logic [AW-1:0] mem_word(input logic [AW-1:0] a);
      return a ^ 16'h5A5A;
   endfunction

   always @(posedge clk) begin
      if (mem_req && !mem_rvalid) begin
         if (mcnt == LAT - 1) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem_word(mem_addr);
            mcnt       <= 0;
         end else begin
            mcnt <= mcnt + 1;
         end
      end else begin
         mem_rvalid <= 1'b0;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic fire(input logic [3:0] m, input logic [AW-1:0] f);
      @(negedge clk);
      mode = m; field_val = f; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 ea_valid", ea_valid, 0);
      check("R1 busy", busy, 0);
      check("R1 mem_req", mem_req, 0);
   endtask

   task automatic t_direct();
      fire(4'd2, 16'd400);
      check("R2 valid", ea_valid, 1);
      check("R2 ea", ea, 400);
      check("R2 is_reg", ea_is_reg, 0);
      @(negedge clk);
      check("R10 pulse ends", ea_valid, 0);
      check("R10 ea held", ea, 400);
   endtask

   task automatic t_immediate();
      field_loc = 16'd351;
      fire(4'd1, 16'd400);
      check("R3 ea", ea, 351);
   endtask

   task automatic t_relative();
      pc_next = 16'd352;
      fire(4'd6, 16'd400);
      check("R4 ea", ea, 752);
      pc_next = 16'hFFF0;
      fire(4'd6, 16'h0020);
      check("R4 wrap", ea, 16'h0010);
   endtask

   task automatic t_base_index();
      reg_idx = 3'd2;
      fire(4'd7, 16'd20);
      check("R5 rf_sel", rf_sel, 2);
      check("R5 base", ea, 3020);
      reg_idx = 3'd1;
      fire(4'd8, 16'd400);
      check("R5 indexed", ea, 600);
   endtask

   task automatic t_reg_ind();
      reg_idx = 3'd1;
      fire(4'd5, 16'd400);
      check("R6 ea", ea, 200);
      check("R6 is_reg", ea_is_reg, 0);
   endtask

   task automatic t_register();
      fire(4'd4, 16'd400);
      check("R7 reg flag", ea_is_reg, 1);
      check("R7 reg ea", ea, 0);
      fire(4'd2, 16'd77);
      fire(4'd0, 16'd400);
      check("R7 implicit flag", ea_is_reg, 1);
      check("R7 implicit ea", ea, 0);
      fire(4'd2, 16'd77);
      fire(4'd12, 16'd400);
      check("R7 unused code", ea_is_reg, 1);
      check("R7 valid", ea_valid, 1);
   endtask

   task automatic t_indirect(input bit poke);
      int waited = 0;
      fire(4'd3, 16'd400);
      check("R8 no early valid", ea_valid, 0);
      check("R8 req", mem_req, 1);
      check("R8 addr", mem_addr, 400);
      check("R10 busy", busy, 1);
      if (poke) begin
         mode = 4'd2; field_val = 16'd999; start = 1'b1;
      end
      while (!ea_valid && waited < 20) begin
         @(negedge clk);
         start = 1'b0;
         waited++;
         if (!ea_valid) check("R8 addr stable", mem_addr, 400);
      end
      check("R8 latency", waited, LAT + 1);
      check("R8 ea", ea, mem_word(16'd400));
      check("R8 is_reg", ea_is_reg, 0);
      check("R8 req drop", mem_req, 0);
      @(negedge clk);
      if (poke) begin
         check("R9 no extra valid", ea_valid, 0);
         check("R9 ea kept", ea, mem_word(16'd400));
      end
   endtask

   initial begin
      for (int i = 0; i < 8; i++) regs[i] = AW'(i * 7);
      regs[1] = 16'd200;
      regs[2] = 16'd3000;
   end

   initial begin
      #3000000;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_direct();
      t_immediate();
      t_relative();
      t_base_index();
      t_reg_ind();
      t_register();
      t_indirect(1'b0);
      t_indirect(1'b1);
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule